// File: doc/BRIEF.md
# Local Interrupt Timer with One-Shot, Periodic and Deadline Modes

This block is a per-core programmable timer that raises an interrupt request carrying an 8-bit vector. Software sets it up through a small register port. A control register selects the vector, a mask and one of three operating modes. The block also has a divide setting, an initial-count register, a read-only current-count register and a deadline register.

In the two countdown modes, writing the initial count loads the current count and starts counting at the divided rate. In one-shot mode the counter stops at zero. In periodic mode it reloads from the initial count. Switching between these two modes never disturbs a countdown that is already running. In deadline mode the countdown is halted and the block compares the deadline against a free-running timestamp input. It fires once when the timestamp reaches the deadline, then clears the deadline.

Register map (word addresses on `reg_addr_i`): 0 control, 1 divide, 2 initial count, 3 current count, 4 deadline. Reads are combinational. Unmapped addresses read zero.

Top module: `lit_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low. A write of N to the initial count (address 2) loads the current count (address 3) with N and clears the prescaler. The count then falls by one on every divided tick. With divide D, `irq_o` is high in the cycle that follows the (N·D)-th clock edge after the write edge.
- R2: In one-shot mode (control bits [10:9] = 0), exactly one interrupt is raised when the count reaches zero, and the count then stays at zero.
- R3: In periodic mode (control bits [10:9] = 1), the count reloads from the initial count when it reaches zero. An interrupt is raised every N·D edges.
- R4: A control write that switches between one-shot and periodic mode partway through a countdown leaves the current count unchanged. Counting continues from there. In periodic mode the next reload happens at zero; in one-shot mode the timer stops at zero.
- R5: If the current count is zero when the mode changes to periodic, the count stays at zero and no interrupt follows.
- R6: Control writes never change the stored initial count.
- R7: The divide register (address 1) uses bits 3, 1 and 0 as a code c = {b3,b1,b0}. c = 7 selects divide-by-1, and c = 0..6 select divide by 2^(c+1), that is 2 through 128. Bit 2 always reads zero.
- R8: In deadline mode (control bits [10:9] = 2), a non-zero deadline (address 4) that is less than or equal to the timestamp fires one interrupt in the next cycle. The deadline then reads zero. A deadline equal to the current timestamp, or already past, fires at once.
- R9: `irq_vec_o` carries control bits [7:0] while `irq_o` is high.
- R10: Control bit 8 masks the interrupt request. Counting continues while it is set.
- R11: Writing zero to the initial count, or to the deadline, stops the timer without raising an interrupt.
- R12: The current-count register is read-only. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data for `reg_addr_i` |
| ts_i | input | DW | Free-running timestamp |
| irq_o | output | 1 | Interrupt request pulse |
| irq_vec_o | output | 8 | Vector delivered with the request |

## Verification
The countdown is run in one-shot and periodic modes with different counts. Mode switches are made mid-count in both directions, which separates a design that reloads on a mode change from one that keeps its count. Each of the eight divide codes is tried with a short count, so a wrong shift shows up as an interrupt in the wrong cycle. Deadlines in the past, equal to the timestamp, in the future and cancelled by a zero write tell apart the fire-at-once, compare-later and disarm behaviours. Masked and zero-count runs confirm that counting and silence are independent.

// File: rtl/lit_pkg.sv
package lit_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_DEADLINE = 2'd2
  } lit_mode_e;

  localparam int LIT_A_CTL  = 0;
  localparam int LIT_A_DIV  = 1;
  localparam int LIT_A_INIT = 2;
  localparam int LIT_A_CUR  = 3;
  localparam int LIT_A_DL   = 4;

  localparam int LIT_PRE_W  = 7;   // largest divide is 2^7
  localparam int LIT_CODE_W = 3;
  localparam int LIT_CTL_W  = 11;  // vector[7:0], mask[8], mode[10:9]
  localparam int LIT_MASK_B = 8;
endpackage

// File: rtl/lit_prescaler.sv
module lit_prescaler
  import lit_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic [LIT_CODE_W-1:0] code_i,
  output logic                  tick_o
);
  logic [LIT_PRE_W-1:0]  pcnt_q;
  logic [LIT_PRE_W-1:0]  sel_mask;
  logic [LIT_CODE_W-1:0] shift;

  assign shift = code_i + LIT_CODE_W'(1);  // code 7 wraps to shift 0

  for (genvar i = 0; i < LIT_PRE_W; i++) begin : g_mask
    assign sel_mask[i] = (LIT_CODE_W'(i) < shift);
  end

  assign tick_o = &(pcnt_q | ~sel_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pcnt_q <= '0;
    else if (clr_i) pcnt_q <= '0;
    else            pcnt_q <= pcnt_q + LIT_PRE_W'(1);
  end
endmodule

// File: rtl/lit_countdown.sv
module lit_countdown #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic [DW-1:0] reload_i,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          periodic_i,
  output logic [DW-1:0] cur_o,
  output logic          fire_o
);
  logic [DW-1:0] cur_q;
  logic          step;

  assign step   = !load_i && run_i && tick_i && (cur_q != '0);
  assign fire_o = step && (cur_q == DW'(1));
  assign cur_o  = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= '0;
    else if (load_i) cur_q <= load_val_i;
    else if (step) begin
      if (cur_q == DW'(1)) cur_q <= periodic_i ? reload_i : '0;
      else                 cur_q <= cur_q - DW'(1);
    end
  end
endmodule

// File: rtl/lit_deadline.sv
module lit_deadline #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_val_i,
  input  logic          arm_i,
  input  logic [DW-1:0] ts_i,
  output logic [DW-1:0] dl_o,
  output logic          fire_o
);
  logic [DW-1:0] dl_q;

  assign fire_o = !wr_i && arm_i && (dl_q != '0) && (ts_i >= dl_q);
  assign dl_o   = dl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dl_q <= '0;
    else if (wr_i)   dl_q <= wr_val_i;
    else if (fire_o) dl_q <= '0;
  end
endmodule

// File: rtl/lit_timer.sv
module lit_timer
  import lit_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [DW-1:0] ts_i,
  output logic          irq_o,
  output logic [7:0]    irq_vec_o
);
  localparam logic [DW-1:0] CTL_MASK = DW'({LIT_CTL_W{1'b1}});
  localparam logic [DW-1:0] DIV_MASK = DW'(4'hB);

  logic [DW-1:0] ctl_q, div_q, init_q;
  logic [DW-1:0] cur_q, dl_q;
  logic          wr_ctl, wr_div, wr_init, wr_dl;
  logic          tick, fire_cd, fire_dl;
  logic          irq_q;
  logic [7:0]    vec_q;
  lit_mode_e     mode;

  assign wr_ctl  = reg_we_i && (reg_addr_i == AW'(LIT_A_CTL));
  assign wr_div  = reg_we_i && (reg_addr_i == AW'(LIT_A_DIV));
  assign wr_init = reg_we_i && (reg_addr_i == AW'(LIT_A_INIT));
  assign wr_dl   = reg_we_i && (reg_addr_i == AW'(LIT_A_DL));
  assign mode    = lit_mode_e'(ctl_q[10:9]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      div_q  <= '0;
      init_q <= '0;
    end else begin
      if (wr_ctl)  ctl_q  <= reg_wdata_i & CTL_MASK;
      if (wr_div)  div_q  <= reg_wdata_i & DIV_MASK;
      if (wr_init) init_q <= reg_wdata_i;
    end
  end

  lit_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_init),
    .code_i ({div_q[3], div_q[1:0]}),
    .tick_o (tick)
  );

  lit_countdown #(.DW(DW)) u_cd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_init),
    .load_val_i (reg_wdata_i),
    .reload_i   (init_q),
    .tick_i     (tick),
    .run_i      (mode != MODE_DEADLINE),
    .periodic_i (mode == MODE_PERIODIC),
    .cur_o      (cur_q),
    .fire_o     (fire_cd)
  );

  lit_deadline #(.DW(DW)) u_dl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_dl),
    .wr_val_i (reg_wdata_i),
    .arm_i    (mode == MODE_DEADLINE),
    .ts_i     (ts_i),
    .dl_o     (dl_q),
    .fire_o   (fire_dl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= (fire_cd || fire_dl) && !ctl_q[LIT_MASK_B];
      if (fire_cd || fire_dl) vec_q <= ctl_q[7:0];
    end
  end

  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;

  always_comb begin
    unique case (reg_addr_i)
      AW'(LIT_A_CTL):  reg_rdata_o = ctl_q;
      AW'(LIT_A_DIV):  reg_rdata_o = div_q;
      AW'(LIT_A_INIT): reg_rdata_o = init_q;
      AW'(LIT_A_CUR):  reg_rdata_o = cur_q;
      AW'(LIT_A_DL):   reg_rdata_o = dl_q;
      default:         reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lit_timer_chk.sv
module lit_timer_chk
  import lit_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] ts_i,
  input logic          irq_o,
  input logic [DW-1:0] ctl_q,
  input logic [DW-1:0] init_q,
  input logic [DW-1:0] cur_q,
  input logic [DW-1:0] dl_q
);
  logic init_wr, dl_wr;
  assign init_wr = reg_we_i && (reg_addr_i == AW'(LIT_A_INIT));
  assign dl_wr   = reg_we_i && (reg_addr_i == AW'(LIT_A_DL));

  AST_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == '0 && !init_wr) |=> (cur_q == '0)); // R5

  AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q > DW'(1) && !init_wr) |=> (cur_q == $past(cur_q) || cur_q == $past(cur_q) - DW'(1))); // R4

  AST_INIT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_wr |=> $stable(init_q)); // R6

  AST_CUR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q <= init_q); // R12

  AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q[LIT_MASK_B] |=> !irq_o); // R10

  AST_DL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q[10:9] == 2'd2 && dl_q != '0 && ts_i >= dl_q && !dl_wr) |=> (dl_q == '0)); // R8
endmodule

bind lit_timer lit_timer_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .ts_i       (ts_i),
  .irq_o      (irq_o),
  .ctl_q      (ctl_q),
  .init_q     (init_q),
  .cur_q      (cur_q),
  .dl_q       (dl_q)
);

// File: tb/tb_lit_timer.sv
`timescale 1ns/1ps
module tb_lit_timer;
  localparam int DW = 32;
  localparam int AW = 3;

  typedef struct packed {
    logic [31:0] c;
    logic [7:0]  v;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [31:0]   cyc;
  logic          irq;
  logic [7:0]    vec;

  int    nchk = 0, nfail = 0;
  bit    done = 0;
  string req = "R1";
  exp_t  q[$];

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 1;
  end

  lit_timer #(.DW(DW), .AW(AW)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .ts_i        (cyc),
    .irq_o       (irq),
    .irq_vec_o   (vec)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", r, act, exp, cyc);
    end
  endtask

  // monitor: compares the request line against the scoreboard every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() != 0 && q[0].c == cyc) begin
        chk({req, " irq"}, {31'd0, irq}, 32'd1);
        chk("R9 vector", {24'd0, vec}, {24'd0, q[0].v});
        void'(q.pop_front());
      end else begin
        chk({req, " idle"}, {31'd0, irq}, 32'd0);
      end
    end
  end

  task automatic push(input logic [31:0] c, input logic [7:0] v);
    q.push_back('{c: c, v: v});
  endtask

  task automatic wr(input int a, input logic [31:0] d, output logic [31:0] e);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    e = cyc;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    addr = AW'(a);
    #1;
    v = rdata;
  endtask

  task automatic wait_to(input logic [31:0] c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic logic [31:0] ctlw(input int mode, input bit mask, input logic [7:0] v);
    return (32'(mode) << 9) | (32'(mask) << 8) | 32'(v);
  endfunction

  initial begin
    logic [31:0] e0, es, v;
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] e0, es, v, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, v); chk("R1 reset reg", v, 32'd0);
    end
    chk("R1 reset irq", {31'd0, irq}, 32'd0);

    // R1 R2 one-shot, divide-by-1
    req = "R2";
    wr(1, 32'hB, es);
    wr(0, ctlw(0, 0, 8'h31), es);
    wr(2, 32'd12, e0);
    push(e0 + 12, 8'h31);
    rd(3, v); chk("R1 load", v, 32'd12);
    wait_to(e0 + 5);
    rd(3, v); chk("R1 count", v, 32'd7);
    wait_to(e0 + 30);
    rd(3, v); chk("R2 stays zero", v, 32'd0);

    // R3 periodic, then R4 switch to one-shot mid-count
    req = "R3";
    wr(0, ctlw(1, 0, 8'h42), es);
    wr(2, 32'd7, e0);
    push(e0 + 7, 8'h42); push(e0 + 14, 8'h42); push(e0 + 21, 8'h42);
    wait_to(e0 + 23);
    req = "R4";
    wr(0, ctlw(0, 0, 8'h42), es);
    rd(3, v); chk("R4 keep count p->o", v, 32'd4);
    push(e0 + 28, 8'h42);
    wait_to(e0 + 45);
    rd(3, v); chk("R4 stopped", v, 32'd0);
    rd(2, v); chk("R6 init kept", v, 32'd7);

    // R4 one-shot to periodic mid-count
    wr(0, ctlw(0, 0, 8'h55), es);
    wr(2, 32'd10, e0);
    wait_to(e0 + 3);
    wr(0, ctlw(1, 0, 8'h55), es);
    rd(3, v); chk("R4 keep count o->p", v, 32'd6);
    push(e0 + 10, 8'h55); push(e0 + 20, 8'h55);
    wait_to(e0 + 23);
    wr(0, ctlw(0, 0, 8'h55), es);
    push(e0 + 30, 8'h55);
    wait_to(e0 + 40);
    rd(3, v); chk("R4 one-shot end", v, 32'd0);
    rd(2, v); chk("R6 init kept", v, 32'd10);

    // R5 periodic while at zero
    req = "R5";
    wr(0, ctlw(1, 0, 8'h55), es);
    wait_to(es + 30);
    rd(3, v); chk("R5 zero hold", v, 32'd0);

    // R7 all divide codes
    req = "R7";
    for (int c = 0; c < 8; c++) begin
      logic [31:0] dv;
      dv = ((32'(c) >> 2) << 3) | (32'(c) & 32'd3);
      d  = 32'd1 << ((c + 1) % 8);
      wr(0, ctlw(0, 0, 8'(8'h60 + c)), es);
      wr(1, dv, es);
      rd(1, v); chk("R7 div readback", v, dv);
      wr(2, 32'd3, e0);
      push(e0 + 3 * d, 8'(8'h60 + c));
      wait_to(e0 + 3 * d + 4);
    end
    wr(1, 32'h4, es);
    rd(1, v); chk("R7 bit2 reads zero", v, 32'd2 & 32'd0);
    wr(1, 32'hB, es);

    // R10 mask
    req = "R10";
    wr(0, ctlw(0, 1, 8'h70), es);
    wr(2, 32'd5, e0);
    wait_to(e0 + 2);
    rd(3, v); chk("R10 counts while masked", v, 32'd3);
    wait_to(e0 + 12);
    rd(3, v); chk("R10 reached zero", v, 32'd0);

    // R11 zero writes
    req = "R11";
    wr(0, ctlw(0, 0, 8'h11), es);
    wr(2, 32'd10, e0);
    wait_to(e0 + 3);
    wr(2, 32'd0, es);
    rd(3, v); chk("R11 init zero stops", v, 32'd0);
    wait_to(es + 20);
    wr(0, ctlw(2, 0, 8'h12), es);
    wr(4, cyc + 20, es);
    wait_to(es + 3);
    wr(4, 32'd0, es);
    wait_to(es + 30);
    rd(4, v); chk("R11 deadline disarmed", v, 32'd0);

    // R12 current count read-only
    req = "R12";
    wr(0, ctlw(0, 0, 8'h21), es);
    wr(2, 32'd50, e0);
    wr(3, 32'd5, es);
    rd(3, v); chk("R12 write ignored", v, 32'd49);
    push(e0 + 50, 8'h21);
    wait_to(e0 + 55);

    // R8 deadline
    req = "R8";
    wr(0, ctlw(2, 0, 8'h9A), es);
    wr(4, cyc - 3, e0);
    push(e0 + 1, 8'h9A);
    wait_to(e0 + 3);
    rd(4, v); chk("R8 past clears", v, 32'd0);
    wr(4, cyc + 1, e0);
    push(e0 + 1, 8'h9A);
    wait_to(e0 + 3);
    rd(4, v); chk("R8 equal clears", v, 32'd0);
    d = cyc + 16;
    wr(4, d, e0);
    rd(4, v); chk("R8 armed", v, d);
    push(d + 1, 8'h9A);
    wait_to(d + 5);
    rd(4, v); chk("R8 future clears", v, 32'd0);

    wait_to(cyc + 10);
    chk("R9 scoreboard drained", 32'(q.size()), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule